// File: doc/BRIEF.md
# Serial Real-Time-Clock Command and Shift Front End

This block sits between a host and the counting core of a serial real-time clock. The host drives a chip select, a strobe, a shift clock, a serial data input, an output enable and three command pins, all asynchronous to the system clock. The block brings these into the system clock domain, latches a command on each qualified strobe edge and presents it as a one-hot mode vector. It keeps the data shift register that carries time words in and out of the chip, and it drives the serial data output.

A command reaches the block in one of two ways. The three pins carry it directly. In the extended variant, holding all three pins high selects a 4-bit serial command register instead. That register is clocked in ahead of the data chain, and the data chain then grows from 40 to 48 bits. On a time-read command the block loads the counter's word into the shift register. On a time-set command it hands the shift register to the counter with a one-cycle load pulse.

Top module: `rtc_cmd_shifter`

## Requirements
- R1: Strobe and shift-clock edges seen while the synchronized chip select is low change neither the latched command nor the data register nor `dout_o`.
- R2: A rising strobe edge latches the command. With pins value n from 0 to 6, `mode_o` becomes the one-hot vector with only bit n set. Bit k of `mode_o` stands for command code k: 0 hold, 1 shift, 2 time set, 3 time read, 15 test.
- R3: When EXTENDED is 0, pins value 7 latches code 15. When EXTENDED is 1, pins value 7 selects serial-command mode and latches the 4-bit serial command register.
- R4: In serial-command mode, each shift-clock rising edge shifts the command register right, with `din_i` entering bit 3. The bit that leaves bit 0 is the input to the data chain.
- R5: While the shift command is latched, each shift-clock rising edge shifts the data register right by one. The input bit enters bit 39 in standard mode and bit 47 in serial-command mode. `dout_o` then equals the new bit 0.
- R6: Latching the shift or time-set command sets `dout_o` to data register bit 0.
- R7: Time read copies `tc_rd_i[39:0]` into the data register in standard mode and all 48 bits in serial-command mode.
- R8: Time set raises `tc_load_o` for exactly one cycle. During that cycle `tc_wr_o` carries the data register, with bits 47:40 forced to zero in standard mode.
- R9: With `oe_i` low, `dout_o` reads 1 unless the test flag is set. Code 15 sets the flag. Codes 0 and 4 to 14 clear it. Codes 1 to 3 leave it unchanged.
- R10: After reset, `mode_o` is 1 (hold), the data and command registers are zero and `dout_o` is 0 with `oe_i` high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cs_i | input | 1 | Chip select, asynchronous |
| stb_i | input | 1 | Command strobe, asynchronous |
| sclk_i | input | 1 | Shift clock, asynchronous |
| din_i | input | 1 | Serial data input, asynchronous |
| oe_i | input | 1 | Output enable for `dout_o` |
| cmd_pins_i | input | 3 | Parallel command pins |
| tc_rd_i | input | 48 | Time word from the counter |
| dout_o | output | 1 | Serial data output, 1 when disabled |
| mode_o | output | 16 | One-hot decoded latched command |
| tc_wr_o | output | 48 | Time word to the counter |
| tc_load_o | output | 1 | One-cycle counter load strobe |

## Verification
The hardest state to reach from the ports is a shift in serial-command mode. There, the first bits entering the data chain come from the command register, not from `din_i`. To get there, the stimulus clocks a shift code into the command register while a non-shifting command is still latched, and then strobes. It reads all 48 bits back and checks that the last bit out is the leftover command bit. Test mode is reached through the same serial path, so the bench can check that `dout_o` stays driven with the output enable low.

// File: rtl/rtc_cmd_shifter.sv
module rtc_cmd_shifter #(
  parameter bit EXTENDED    = 1'b1,
  parameter int BYTE_W      = 8,
  parameter int STD_BYTES   = 5,
  parameter int EXT_BYTES   = 6,
  parameter int CMD_W       = 4,
  parameter int PIN_W       = 3,
  parameter int SYNC_STAGES = 2
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        cs_i,
  input  logic                        stb_i,
  input  logic                        sclk_i,
  input  logic                        din_i,
  input  logic                        oe_i,
  input  logic [PIN_W-1:0]            cmd_pins_i,
  input  logic [BYTE_W*EXT_BYTES-1:0] tc_rd_i,
  output logic                        dout_o,
  output logic [(1<<CMD_W)-1:0]       mode_o,
  output logic [BYTE_W*EXT_BYTES-1:0] tc_wr_o,
  output logic                        tc_load_o
);
  localparam int DW    = BYTE_W * EXT_BYTES;
  localparam int SW    = BYTE_W * STD_BYTES;
  localparam int NMODE = 1 << CMD_W;
  localparam logic [CMD_W-1:0] C_HOLD  = CMD_W'(0);
  localparam logic [CMD_W-1:0] C_SHIFT = CMD_W'(1);
  localparam logic [CMD_W-1:0] C_SET   = CMD_W'(2);
  localparam logic [CMD_W-1:0] C_READ  = CMD_W'(3);
  localparam logic [CMD_W-1:0] C_PULSE = CMD_W'(4);
  localparam logic [CMD_W-1:0] C_TEST  = CMD_W'(NMODE - 1);

  logic [SYNC_STAGES-1:0] cs_sy, stb_sy, sclk_sy, din_sy;
  logic                   stb_d, sclk_d;
  logic [CMD_W-1:0]       cmd_q, creg_q;
  logic [DW-1:0]          dreg_q;
  logic                   dbit_q, test_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cs_sy   <= '0;
      stb_sy  <= '0;
      sclk_sy <= '0;
      din_sy  <= '0;
      stb_d   <= 1'b0;
      sclk_d  <= 1'b0;
    end else begin
      cs_sy   <= {cs_sy[SYNC_STAGES-2:0], cs_i};
      stb_sy  <= {stb_sy[SYNC_STAGES-2:0], stb_i};
      sclk_sy <= {sclk_sy[SYNC_STAGES-2:0], sclk_i};
      din_sy  <= {din_sy[SYNC_STAGES-2:0], din_i};
      stb_d   <= stb_sy[SYNC_STAGES-1];
      sclk_d  <= sclk_sy[SYNC_STAGES-1];
    end
  end

  wire cs_s      = cs_sy[SYNC_STAGES-1];
  wire din_s     = din_sy[SYNC_STAGES-1];
  wire stb_rise  = cs_s & stb_sy[SYNC_STAGES-1] & ~stb_d;
  wire sclk_rise = cs_s & sclk_sy[SYNC_STAGES-1] & ~sclk_d;
  wire all_high  = &cmd_pins_i;
  wire ser_mode  = EXTENDED & all_high;

  wire [CMD_W-1:0] par_cmd  = all_high ? C_TEST : CMD_W'(cmd_pins_i);
  wire [CMD_W-1:0] new_cmd  = ser_mode ? creg_q : par_cmd;
  wire             chain_in = ser_mode ? creg_q[0] : din_s;

  logic [DW-1:0] shift_nx, read_nx, set_word;
  always_comb begin
    if (ser_mode) begin
      shift_nx = {chain_in, dreg_q[DW-1:1]};
      read_nx  = tc_rd_i;
      set_word = dreg_q;
    end else begin
      shift_nx = {dreg_q[DW-1:SW], chain_in, dreg_q[SW-1:1]};
      read_nx  = {dreg_q[DW-1:SW], tc_rd_i[SW-1:0]};
      set_word = {{(DW-SW){1'b0}}, dreg_q[SW-1:0]};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      creg_q <= '0;
    end else if (sclk_rise && ser_mode) begin
      creg_q <= {din_s, creg_q[CMD_W-1:1]};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmd_q     <= C_HOLD;
      dreg_q    <= '0;
      dbit_q    <= 1'b0;
      test_q    <= 1'b0;
      tc_wr_o   <= '0;
      tc_load_o <= 1'b0;
    end else begin
      tc_load_o <= 1'b0;
      if (stb_rise) begin
        cmd_q <= new_cmd;
        if (new_cmd == C_TEST)
          test_q <= 1'b1;
        else if (new_cmd == C_HOLD || new_cmd >= C_PULSE)
          test_q <= 1'b0;
        case (new_cmd)
          C_SHIFT: dbit_q <= dreg_q[0];
          C_SET: begin
            dbit_q    <= dreg_q[0];
            tc_wr_o   <= set_word;
            tc_load_o <= 1'b1;
          end
          C_READ:  dreg_q <= read_nx;
          default: ;
        endcase
      end else if (sclk_rise && cmd_q == C_SHIFT) begin
        dreg_q <= shift_nx;
        dbit_q <= shift_nx[0];
      end
    end
  end

  assign dout_o = (oe_i | test_q) ? dbit_q : 1'b1;
  assign mode_o = NMODE'(1) << cmd_q;
endmodule

// File: rtl/rtc_cmd_shifter_chk.sv
module rtc_cmd_shifter_chk #(
  parameter int DW    = 48,
  parameter int CMD_W = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic             cs_s,
  input logic             stb_rise,
  input logic             sclk_rise,
  input logic             ser_mode,
  input logic [CMD_W-1:0] cmd_q,
  input logic [CMD_W-1:0] creg_q,
  input logic [DW-1:0]    dreg_q,
  input logic             test_q,
  input logic             tc_load_o
);
  a_r1_cs_gate: assert property (@(posedge clk) disable iff (!rst_n)
    !cs_s |=> ($stable(cmd_q) && $stable(dreg_q)));

  a_r5_data_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!stb_rise && !(sclk_rise && cmd_q == CMD_W'(1))) |=> $stable(dreg_q));

  a_r4_creg_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !ser_mode |=> $stable(creg_q));

  a_r8_load_cmd: assert property (@(posedge clk) disable iff (!rst_n)
    tc_load_o |-> (cmd_q == CMD_W'(2)));

  a_r9_test_flag: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_q == {CMD_W{1'b1}}) |-> test_q);
endmodule

bind rtc_cmd_shifter rtc_cmd_shifter_chk #(.DW(BYTE_W*EXT_BYTES), .CMD_W(CMD_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .cs_s(cs_s), .stb_rise(stb_rise), .sclk_rise(sclk_rise),
  .ser_mode(ser_mode), .cmd_q(cmd_q), .creg_q(creg_q), .dreg_q(dreg_q),
  .test_q(test_q), .tc_load_o(tc_load_o)
);

// File: tb/test_rtc_cmd_shifter.sv
module test_rtc_cmd_shifter;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cs = 1'b1, stb = 1'b0, sclk = 1'b0, din = 1'b0, oe = 1'b1;
  logic [2:0]  pins = 3'd0;
  logic [47:0] rd = '0;
  logic        dout, dout_b, load, load_b;
  logic [15:0] mode, mode_b;
  logic [47:0] wr, wr_b, wr_cap;
  int total = 0, bad = 0, loads = 0;

  localparam logic [47:0] RD = 48'h9C_3A5E_61D7_B2;
  localparam logic [39:0] P  = 40'h5B_E21C_9A37;
  // {pins, expected code extended, expected code base}
  localparam logic [10:0] TAB [8] = '{
    {3'd0, 4'd0, 4'd0},  {3'd1, 4'd1, 4'd1},  {3'd2, 4'd2, 4'd2},  {3'd3, 4'd3, 4'd3},
    {3'd4, 4'd4, 4'd4},  {3'd5, 4'd5, 4'd5},  {3'd6, 4'd6, 4'd6},  {3'd7, 4'd0, 4'd15}};

  always #2.5 clk = ~clk;

  rtc_cmd_shifter i_rtc_cmd_shifter (
    .clk(clk), .rst_n(rst_n), .cs_i(cs), .stb_i(stb), .sclk_i(sclk), .din_i(din),
    .oe_i(oe), .cmd_pins_i(pins), .tc_rd_i(rd), .dout_o(dout), .mode_o(mode),
    .tc_wr_o(wr), .tc_load_o(load));

  rtc_cmd_shifter #(.EXTENDED(1'b0)) i_rtc_cmd_shifter_base (
    .clk(clk), .rst_n(rst_n), .cs_i(cs), .stb_i(stb), .sclk_i(sclk), .din_i(din),
    .oe_i(oe), .cmd_pins_i(pins), .tc_rd_i(rd), .dout_o(dout_b), .mode_o(mode_b),
    .tc_wr_o(wr_b), .tc_load_o(load_b));

  always @(posedge clk) if (load) begin loads <= loads + 1; wr_cap <= wr; end

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wt(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic strobe();
    stb = 1'b1; wt(4); stb = 1'b0; wt(4);
  endtask

  task automatic shclk(input logic d);
    din = d; wt(4); sclk = 1'b1; wt(4); sclk = 1'b0; wt(4);
  endtask

  task automatic summary();
    $display("test done: total=%0d bad=%0d", total, bad);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog actual=running expected=finished");
    summary();
    $finish;
  end

  initial begin
    int l0;
    rd = RD;
    wt(5); rst_n = 1'b1; wt(2);
    chk("R10 mode after reset", mode, 16'h0001);
    chk("R10 dout after reset", dout, 1'b0);
    chk("R10 base mode after reset", mode_b, 16'h0001);

    foreach (TAB[i]) begin
      pins = TAB[i][10:8]; wt(1); strobe();
      chk("R2 R3 extended decode", mode, 16'h1 << TAB[i][7:4]);
      chk("R2 R3 base decode", mode_b, 16'h1 << TAB[i][3:0]);
    end

    pins = 3'd3; wt(1); strobe();
    pins = 3'd1; wt(1); strobe();
    chk("R6 shift entry dout", dout, RD[0]);
    for (int k = 0; k < 40; k++) begin
      shclk(P[k]);
      chk("R5 R7 std readout", dout, (k < 39) ? RD[k+1] : P[0]);
    end
    l0 = loads;
    pins = 3'd2; wt(1); strobe();
    chk("R8 single load pulse", loads - l0, 1);
    chk("R8 set word", wr_cap, {8'h00, P});
    chk("R6 set entry dout", dout, P[0]);

    oe = 1'b0; wt(1);
    chk("R9 oe low reads high", dout, 1'b1);
    oe = 1'b1; wt(1);
    chk("R9 oe high restores", dout, P[0]);

    pins = 3'd7; wt(1);
    shclk(1'b1); shclk(1'b1); shclk(1'b0); shclk(1'b0);
    strobe();
    chk("R4 serial read command", mode, 16'h0008);
    shclk(1'b1); shclk(1'b0); shclk(1'b0); shclk(1'b0);
    strobe();
    chk("R4 serial shift command", mode, 16'h0002);
    chk("R6 serial shift entry", dout, RD[0]);
    for (int k = 0; k < 48; k++) begin
      shclk(1'b0);
      chk("R4 R5 R7 serial readout", dout, (k < 47) ? RD[k+1] : 1'b1);
    end
    shclk(1'b1); shclk(1'b1); shclk(1'b1); shclk(1'b1);
    strobe();
    chk("R9 serial test command", mode, 16'h8000);
    oe = 1'b0; wt(1);
    chk("R9 test keeps dout driven", dout, 1'b0);
    shclk(1'b0); shclk(1'b0); shclk(1'b0); shclk(1'b0);
    strobe();
    chk("R9 hold command", mode, 16'h0001);
    chk("R9 hold clears test", dout, 1'b1);
    oe = 1'b1;

    pins = 3'd3; wt(1); strobe();
    pins = 3'd1; wt(1); strobe();
    chk("R6 shift entry again", dout, RD[0]);
    cs = 1'b0; wt(4);
    shclk(1'b0);
    chk("R1 clock ignored", dout, RD[0]);
    pins = 3'd3; wt(1); strobe();
    chk("R1 strobe ignored", mode, 16'h0002);
    cs = 1'b1; wt(4);
    shclk(1'b0);
    chk("R1 R5 clock after select", dout, RD[1]);

    summary();
    $finish;
  end
endmodule